// File: doc/BRIEF.md
# Suspend and Wake Controller

This block sits next to a small CPU and an always-on clock. It puts the CPU into one of two suspend states and decides how it comes back. A light suspend (halt) stops only the CPU clock. The oscillators keep running, and the peripheral clock stays as software left it. A deep suspend (sleep) stops the CPU clock, the peripheral clock and both oscillators. The CPU raises a one-cycle request when it executes its halt or sleep instruction.

There are three groups of wake sources: port or debug break, slow-clock peripherals, and fast-clock peripherals. Each is synchronized with two flops before use. Which groups may end a suspend depends on the suspend state and on whether the peripheral clock was running at entry. On resume the block gives a one-cycle strobe and a flag that tells the CPU to enter the handler or to continue with the next instruction. If an enabled source wakes the CPU while the peripheral clock is stopped, its interrupt is held pending. It is released only once that clock is enabled again.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset the block is running. `cpuClkEn`, `fastOscEn` and `slowOscEn` are 1, `pclkGate` follows `pclkEn`, and `resumeStb`, `takeIrq`, `irqPend` and `irqFire` are 0.
- R2: In sleep, `cpuClkEn`, `pclkGate`, `fastOscEn` and `slowOscEn` are all 0. Only a port source ends sleep; slow and fast sources have no effect.
- R3: In halt, `cpuClkEn` is 0, both oscillator enables are 1, and `pclkGate` holds the `pclkEn` value sampled with the halt request.
- R4: In halt entered with the peripheral clock stopped, a port source or a slow source ends the suspend, and a fast source does not.
- R5: In halt entered with the peripheral clock running, a fast source ends the suspend only when its bit in `fastIntEn` is 1.
- R6: A wake input held high from a point before clock edge k raises `resumeStb` after edge k+2, for exactly one cycle. `cpuClkEn` is 1 from that same edge.
- R7: `takeIrq` is 1 in the strobe cycle exactly when a waking source has its enable bit set, `cpuIe` is 1, and the peripheral clock was running at entry.
- R8: A port or slow source whose enable bit is 0, or any waking source while `cpuIe` is 0, still resumes the CPU, with `takeIrq` at 0.
- R9: If the peripheral clock was stopped at entry, each enabled source that wakes the CPU sets its bit in `irqPend`, and `takeIrq` stays 0. The bit order is port bits from bit 0, then slow bits, then fast bits.
- R10: Pending bits stay set while `pclkEn` is 0. After the first edge with `pclkEn` at 1, `irqFire` shows those bits for one cycle and `irqPend` clears.
- R11: A suspend request that arrives while a qualifying synchronized wake source is active gives `resumeStb` after the next edge, and no clock enable drops.
- R12: When `sleepReq` and `haltReq` arrive in the same cycle, sleep is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| haltReq | input | 1 | One-cycle light suspend request |
| sleepReq | input | 1 | One-cycle deep suspend request |
| portWake | input | NPORT | Port or debug break wake sources (asynchronous) |
| slowWake | input | NSLOW | Slow-clock peripheral wake sources (asynchronous) |
| fastWake | input | NFAST | Fast-clock peripheral wake sources (asynchronous) |
| portIntEn | input | NPORT | Interrupt controller enables for port sources |
| slowIntEn | input | NSLOW | Interrupt controller enables for slow sources |
| fastIntEn | input | NFAST | Interrupt controller enables for fast sources |
| cpuIe | input | 1 | CPU global interrupt enable flag |
| pclkEn | input | 1 | Software setting of the peripheral clock |
| cpuClkEn | output | 1 | CPU clock gate enable |
| pclkGate | output | 1 | Peripheral clock gate enable |
| fastOscEn | output | 1 | Fast oscillator enable |
| slowOscEn | output | 1 | Slow oscillator enable |
| resumeStb | output | 1 | One-cycle resume strobe |
| takeIrq | output | 1 | With the strobe: 1 enter handler, 0 continue |
| irqPend | output | NPORT+NSLOW+NFAST | Interrupts held while the peripheral clock is off |
| irqFire | output | NPORT+NSLOW+NFAST | One-cycle release of held interrupts |

## Verification
On every cycle the assertions check these properties: the resume strobe is one cycle wide, the handler flag appears only with the strobe, the CPU clock runs in the strobe cycle, and sleep turns off every enable together. They also check that the peripheral gate stays still during a halt and that released interrupts follow an enabled peripheral clock. Only the bench scenarios can show which groups wake which mode, that the resume latency matches, and that the handler-or-continue choice is correct. They also cover which bits become pending, immediate resume on a request that meets an active source, and the priority of sleep over halt.

// File: rtl/lp_wake_pkg.sv
package lp_wake_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_SLEEP} lpState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic inRun;    // controller is in the running state
    logic capture;  // sample pclkEn at suspend entry
    logic resolve;  // resume happens at this edge
    logic haltMode; // the resolving suspend is a halt
  } lpCtl_t;
endpackage

// File: rtl/lp_wake_sync.sv
module lp_wake_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      dout <= '0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/lp_wake_path.sv
module lp_wake_path
  import lp_wake_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int NSLOW = 4,
  parameter int NFAST = 4,
  localparam int NSRC = NPORT + NSLOW + NFAST
) (
  input  logic             clk,
  input  logic             rstN,
  input  lpCtl_t           ctl,
  input  logic [NPORT-1:0] portWake,
  input  logic [NSLOW-1:0] slowWake,
  input  logic [NFAST-1:0] fastWake,
  input  logic [NPORT-1:0] portIntEn,
  input  logic [NSLOW-1:0] slowIntEn,
  input  logic [NFAST-1:0] fastIntEn,
  input  logic             cpuIe,
  input  logic             pclkEn,
  output logic             wakeHalt,
  output logic             wakeSleep,
  output logic             pclkAtSus,
  output logic             takeIrq,
  output logic [NSRC-1:0]  irqPend,
  output logic [NSRC-1:0]  irqFire
);
  logic [NPORT-1:0] portS;
  logic [NSLOW-1:0] slowS;
  logic [NFAST-1:0] fastS;

  lp_wake_sync #(.W(NPORT)) portSync (.clk(clk), .rstN(rstN), .din(portWake), .dout(portS));
  lp_wake_sync #(.W(NSLOW)) slowSync (.clk(clk), .rstN(rstN), .din(slowWake), .dout(slowS));
  lp_wake_sync #(.W(NFAST)) fastSync (.clk(clk), .rstN(rstN), .din(fastWake), .dout(fastS));

  logic             pclkRef;
  logic [NFAST-1:0] fastHit;
  logic [NSRC-1:0]  enMask;

  always_comb begin
    pclkRef   = ctl.inRun ? pclkEn : pclkAtSus;
    fastHit   = fastS & fastIntEn;
    wakeSleep = |portS;
    wakeHalt  = (|portS) || (|slowS) || (pclkRef && (|fastHit));
    enMask    = {(ctl.haltMode && pclkRef) ? fastHit : '0,
                 ctl.haltMode ? (slowS & slowIntEn) : '0,
                 portS & portIntEn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pclkAtSus <= 1'b0;
      takeIrq   <= 1'b0;
      irqPend   <= '0;
      irqFire   <= '0;
    end else begin
      if (ctl.capture) pclkAtSus <= pclkEn;
      takeIrq <= ctl.resolve && (|enMask) && cpuIe && pclkRef;
      irqPend <= (irqPend & ~{NSRC{pclkEn}})
               | ((ctl.resolve && !pclkRef) ? enMask : '0);
      irqFire <= pclkEn ? irqPend : '0;
    end
  end
endmodule

// File: rtl/lp_wake_fsm.sv
module lp_wake_fsm
  import lp_wake_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   haltReq,
  input  logic   sleepReq,
  input  logic   wakeHalt,
  input  logic   wakeSleep,
  input  logic   pclkEn,
  input  logic   pclkAtSus,
  output lpCtl_t ctl,
  output logic   resumeStb,
  output logic   cpuClkEn,
  output logic   pclkGate,
  output logic   fastOscEn,
  output logic   slowOscEn
);
  lpState_t state, stateNx;

  always_comb begin
    stateNx = state;
    ctl     = '0;
    ctl.inRun = (state == ST_RUN);
    unique case (state)
      ST_RUN: begin
        if (sleepReq) begin
          if (wakeSleep) ctl.resolve = 1'b1;
          else begin ctl.capture = 1'b1; stateNx = ST_SLEEP; end
        end else if (haltReq) begin
          ctl.haltMode = 1'b1;
          if (wakeHalt) ctl.resolve = 1'b1;
          else begin ctl.capture = 1'b1; stateNx = ST_HALT; end
        end
      end
      ST_HALT: begin
        ctl.haltMode = 1'b1;
        if (wakeHalt) begin ctl.resolve = 1'b1; stateNx = ST_RUN; end
      end
      ST_SLEEP: begin
        if (wakeSleep) begin ctl.resolve = 1'b1; stateNx = ST_RUN; end
      end
      default: stateNx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      resumeStb <= 1'b0;
    end else begin
      state     <= stateNx;
      resumeStb <= ctl.resolve;
    end
  end

  always_comb begin
    cpuClkEn  = (state == ST_RUN);
    fastOscEn = (state != ST_SLEEP);
    slowOscEn = (state != ST_SLEEP);
    case (state)
      ST_RUN:  pclkGate = pclkEn;
      ST_HALT: pclkGate = pclkAtSus;
      default: pclkGate = 1'b0;
    endcase
  end
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
  import lp_wake_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int NSLOW = 4,
  parameter int NFAST = 4,
  localparam int NSRC = NPORT + NSLOW + NFAST
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltReq,
  input  logic             sleepReq,
  input  logic [NPORT-1:0] portWake,
  input  logic [NSLOW-1:0] slowWake,
  input  logic [NFAST-1:0] fastWake,
  input  logic [NPORT-1:0] portIntEn,
  input  logic [NSLOW-1:0] slowIntEn,
  input  logic [NFAST-1:0] fastIntEn,
  input  logic             cpuIe,
  input  logic             pclkEn,
  output logic             cpuClkEn,
  output logic             pclkGate,
  output logic             fastOscEn,
  output logic             slowOscEn,
  output logic             resumeStb,
  output logic             takeIrq,
  output logic [NSRC-1:0]  irqPend,
  output logic [NSRC-1:0]  irqFire
);
  lpCtl_t ctl;
  logic   wakeHalt, wakeSleep, pclkAtSus;

  lp_wake_fsm fsm (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .sleepReq(sleepReq),
    .wakeHalt(wakeHalt), .wakeSleep(wakeSleep), .pclkEn(pclkEn),
    .pclkAtSus(pclkAtSus), .ctl(ctl), .resumeStb(resumeStb),
    .cpuClkEn(cpuClkEn), .pclkGate(pclkGate),
    .fastOscEn(fastOscEn), .slowOscEn(slowOscEn)
  );

  lp_wake_path #(.NPORT(NPORT), .NSLOW(NSLOW), .NFAST(NFAST)) path (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .portWake(portWake), .slowWake(slowWake), .fastWake(fastWake),
    .portIntEn(portIntEn), .slowIntEn(slowIntEn), .fastIntEn(fastIntEn),
    .cpuIe(cpuIe), .pclkEn(pclkEn),
    .wakeHalt(wakeHalt), .wakeSleep(wakeSleep), .pclkAtSus(pclkAtSus),
    .takeIrq(takeIrq), .irqPend(irqPend), .irqFire(irqFire)
  );
endmodule

// File: rtl/lp_wake_chk.sv
module lp_wake_chk #(
  parameter int NSRC = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic            pclkEn,
  input logic            cpuClkEn,
  input logic            pclkGate,
  input logic            fastOscEn,
  input logic            slowOscEn,
  input logic            resumeStb,
  input logic            takeIrq,
  input logic [NSRC-1:0] irqFire
);
  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeStb |=> !resumeStb);

  // R7
  take_with_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> resumeStb);

  // R11
  resume_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeStb |-> cpuClkEn);

  // R2
  sleep_all_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !slowOscEn |-> (!fastOscEn && !cpuClkEn && !pclkGate));

  // R3
  halt_gate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkEn && fastOscEn && $past(!cpuClkEn)) |-> $stable(pclkGate));

  // R10
  fire_after_pclk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|irqFire) |-> $past(pclkEn));
endmodule

bind lp_wake_ctrl lp_wake_chk #(.NSRC(NPORT + NSLOW + NFAST)) chkInst (
  .clk(clk), .rstN(rstN), .pclkEn(pclkEn), .cpuClkEn(cpuClkEn),
  .pclkGate(pclkGate), .fastOscEn(fastOscEn), .slowOscEn(slowOscEn),
  .resumeStb(resumeStb), .takeIrq(takeIrq), .irqFire(irqFire)
);

// File: tb/lp_wake_ctrl_test.sv
module lp_wake_ctrl_test;
  localparam int NP = 2, NS = 2, NF = 2, NT = NP + NS + NF;

  logic clk = 0, rstN = 0;
  logic haltReq = 0, sleepReq = 0, cpuIe = 0, pclkEn = 0;
  logic [NP-1:0] portWake = '0, portIntEn = '0;
  logic [NS-1:0] slowWake = '0, slowIntEn = '0;
  logic [NF-1:0] fastWake = '0, fastIntEn = '0;
  logic cpuClkEn, pclkGate, fastOscEn, slowOscEn, resumeStb, takeIrq;
  logic [NT-1:0] irqPend, irqFire;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lp_wake_ctrl #(.NPORT(NP), .NSLOW(NS), .NFAST(NF)) uut (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .sleepReq(sleepReq),
    .portWake(portWake), .slowWake(slowWake), .fastWake(fastWake),
    .portIntEn(portIntEn), .slowIntEn(slowIntEn), .fastIntEn(fastIntEn),
    .cpuIe(cpuIe), .pclkEn(pclkEn), .cpuClkEn(cpuClkEn), .pclkGate(pclkGate),
    .fastOscEn(fastOscEn), .slowOscEn(slowOscEn), .resumeStb(resumeStb),
    .takeIrq(takeIrq), .irqPend(irqPend), .irqFire(irqFire)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearAll();
    haltReq = 0; sleepReq = 0; portWake = '0; slowWake = '0; fastWake = '0;
    portIntEn = '0; slowIntEn = '0; fastIntEn = '0;
  endtask

  // one suspend/wake scenario: sl=1 sleep else halt, g group, b bit
  task automatic runCase(input bit sl, input bit p, input int g, input int b,
                         input bit en, input bit ie);
    bit woke, expTake;
    logic [NT-1:0] expPend;
    int strobes, takeSeen, base;
    @(negedge clk);
    clearAll(); pclkEn = p; cpuIe = ie;
    base = (g == 0) ? 0 : (g == 1) ? NP : NP + NS;
    if (g == 0) portIntEn[b] = en; else if (g == 1) slowIntEn[b] = en; else fastIntEn[b] = en;
    @(negedge clk);
    if (sl) sleepReq = 1; else haltReq = 1;
    @(negedge clk);
    haltReq = 0; sleepReq = 0;
    if (sl) check("R2", {cpuClkEn, pclkGate, fastOscEn, slowOscEn}, 4'b0000);
    else    check("R3", {cpuClkEn, pclkGate, fastOscEn, slowOscEn}, {1'b0, p, 2'b11});
    if (g == 0) portWake[b] = 1; else if (g == 1) slowWake[b] = 1; else fastWake[b] = 1;
    woke = (g == 0) || (!sl && (g == 1 || (p && en)));
    expTake = woke && en && ie && p;
    expPend = '0;
    if (woke && en && !p) expPend[base + b] = 1'b1;
    strobes = 0; takeSeen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 1) check("R6 no early strobe", resumeStb, 1'b0);
      if (i == 2 && woke) check("R6 latency", {resumeStb, cpuClkEn}, 2'b11);
      if (resumeStb) begin strobes++; takeSeen = takeIrq; end
    end
    portWake = '0; slowWake = '0; fastWake = '0;
    if (sl) check(woke ? "R2 port wakes" : "R2 ignored", strobes, woke);
    else if (!p) check(g == 2 ? "R4 fast ignored" : "R4 wakes", strobes, woke);
    else check(g == 2 ? "R5 fast enable" : "R5 wakes", strobes, woke);
    if (woke) begin
      if (expTake) check("R7 handler", takeSeen, 1);
      else check(p ? "R8 continue" : "R9 no handler", takeSeen, 0);
      check("R9 pending", irqPend, expPend);
    end else begin
      check("R2 still gated", cpuClkEn, 1'b0);
      repeat (3) @(negedge clk);
      portWake[0] = 1;
      repeat (4) @(negedge clk);
      portWake = '0;
      check("R8 release by disabled port", cpuClkEn, 1'b1);
    end
    repeat (2) @(negedge clk);
    check("R10 held", irqPend, expPend);
    pclkEn = 1;
    @(negedge clk);
    check("R10 fire", irqFire, expPend);
    @(negedge clk);
    check("R10 cleared", {irqPend, irqFire}, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    pclkEn = 1;
    #1;
    check("R1 reset", {cpuClkEn, fastOscEn, slowOscEn, resumeStb, takeIrq}, 5'b11100);
    rstN = 1;
    @(negedge clk);
    check("R1 gate follows", pclkGate, 1'b1);
    check("R1 pend", {irqPend, irqFire}, '0);
    pclkEn = 0;
    #1 check("R1 gate follows low", pclkGate, 1'b0);

    for (int sl = 0; sl < 2; sl++)
      for (int p = 0; p < 2; p++)
        for (int g = 0; g < 3; g++)
          for (int b = 0; b < 2; b++)
            for (int en = 0; en < 2; en++)
              for (int ie = 0; ie < 2; ie++)
                runCase(sl[0], p[0], g, b, en[0], ie[0]);

    // R11 immediate resume
    @(negedge clk);
    clearAll(); pclkEn = 1; cpuIe = 1; portIntEn[1] = 1; portWake[1] = 1;
    repeat (3) @(negedge clk);
    haltReq = 1;
    @(negedge clk);
    haltReq = 0;
    check("R11 strobe", {resumeStb, takeIrq, cpuClkEn, fastOscEn}, 4'b1111);
    @(negedge clk);
    check("R11 stays running", {resumeStb, cpuClkEn}, 2'b01);
    portWake = '0;
    repeat (4) @(negedge clk);

    // R12 sleep wins
    haltReq = 1; sleepReq = 1;
    @(negedge clk);
    clearAll();
    check("R12 sleep priority", {fastOscEn, cpuClkEn}, 2'b00);
    portWake[0] = 1;
    repeat (4) @(negedge clk);
    portWake = '0;
    check("R12 back running", cpuClkEn, 1'b1);
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule